// File: doc/BRIEF.md
# Protection Bit Bank Erase-All Controller

This block drives a small bank of non-volatile protection bits, one bit per array sector. The bank itself offers only two raw operations. A program pulse locks a single bit chosen by index. An erase pulse unlocks every bit of the bank at once, because the bank behaves like one tiny sector. Erasing cells that are not fully programmed over-erases them. For that reason the controller provides a safe bank-wide unlock command. It first programs every protection bit, so every sector is briefly locked, and only then fires the erase pulse.

While the controller is idle, the host may also program single bits and may request a bare erase pulse. A bare erase is only applied when every bit is already programmed. Otherwise it is refused, and a sticky error flag records the refusal. The state of each cell is available in two forms: as a decoded locked flag, and as a raw read value. A parameter sets which read level stands for the programmed state.

Top module: `pb_erase_ctrl`

## Requirements
- R1: After reset every protection bit is erased (locked_o all 0), and busy_o, done_o, err_o, pgm_pulse_o and ers_pulse_o are all 0.
- R2: While idle, a prog_i request with an in-range index k raises pgm_pulse_o with pgm_idx_o = k in the same cycle. From the next cycle on, bit k of locked_o is 1 and all other bits are unchanged.
- R3: An erase_all_i request sampled while idle raises busy_o in the next cycle. Over the next N_BITS cycles it issues one program pulse per cycle, with indices 0, 1, ..., N_BITS-1 in ascending order.
- R4: The sequence issues exactly one erase pulse, in the cycle right after the last program pulse. An erase pulse is never issued while any bit is unlocked, and program and erase pulses never coincide.
- R5: In the cycle after the sequence's erase pulse, every bit is erased, busy_o is 0 and done_o is 1. done_o stays high for that one cycle only.
- R6: While busy_o is 1, host prog_i requests are ignored: the index of the pulse stays the sequence index, and the requested bit is not locked.
- R7: A raw_erase_i request while idle with at least one bit unlocked produces no erase pulse and leaves locked_o unchanged. It sets err_o from the next cycle, and err_o stays 1 until reset.
- R8: A raw_erase_i request while idle with every bit locked raises ers_pulse_o in the same cycle. All bits are erased from the next cycle, and err_o is not changed.
- R9: rd_bits_o equals locked_o when PROG_READS_ONE = 1. It equals the bitwise inverse of locked_o when PROG_READS_ONE = 0.
- R10: When several requests arrive together while idle, erase_all_i wins over raw_erase_i, and raw_erase_i wins over prog_i. A losing request has no effect, and in particular it sets no error.
- R11: erase_all_i and raw_erase_i are ignored while busy_o is 1. They neither restart the sequence nor set err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| erase_all_i | input | 1 | Request the safe preprogram-then-erase sequence |
| prog_i | input | 1 | Host request to program one bit |
| prog_idx_i | input | IW | Index of the bit to program |
| raw_erase_i | input | 1 | Host request for a bare bank erase pulse |
| locked_o | output | N_BITS | Decoded state per bit, 1 = programmed (sector locked) |
| rd_bits_o | output | N_BITS | Raw read value per bit under the configured polarity |
| pgm_pulse_o | output | 1 | Program pulse applied to the bank this cycle |
| pgm_idx_o | output | IW | Index the program pulse targets |
| ers_pulse_o | output | 1 | Bank-wide erase pulse applied this cycle |
| busy_o | output | 1 | Erase-all sequence in progress |
| done_o | output | 1 | One-cycle completion strobe of the sequence |
| err_o | output | 1 | Sticky flag: a bare erase was refused |

## Verification
The assertions assume that the request inputs are synchronous to clk and are held at defined levels after reset. They also assume that prog_idx_i is in range whenever prog_i is high. The ascending-order property further assumes that the host never pulses erase_all_i in a way that could be read as a restart, and R11 guarantees this at the ports. The bench changes every input only on the falling edge and uses only indices below N_BITS. It also raises conflicting requests on purpose, both during busy and in the same idle cycle, so that the priority and ignore rules are exercised inside those limits.

// File: rtl/pb_pkg.sv
package pb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PRE  = 2'd1,
      ST_ERS  = 2'd2,
      ST_FIN  = 2'd3
   } pb_state_e;

endpackage

// File: rtl/pb_cell_bank.sv
module pb_cell_bank #(
   parameter int N_BITS         = 16,
   parameter int IW             = 4,
   parameter bit PROG_READS_ONE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pgm_pulse_i,
   input  logic [IW-1:0]     pgm_idx_i,
   input  logic              ers_pulse_i,
   output logic [N_BITS-1:0] locked_o,
   output logic [N_BITS-1:0] rd_bits_o
);

   // one storage cell per sector; erase acts on all cells together
   for (genvar gi = 0; gi < N_BITS; gi++) begin : g_cell
      logic hit;
      assign hit = pgm_pulse_i && (pgm_idx_i == IW'(gi));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            locked_o[gi] <= 1'b0;
         end else if (ers_pulse_i) begin
            locked_o[gi] <= 1'b0;
         end else if (hit) begin
            locked_o[gi] <= 1'b1;
         end
      end
   end

   // read polarity variant
   if (PROG_READS_ONE) begin : g_pol_direct
      assign rd_bits_o = locked_o;
   end else begin : g_pol_invert
      assign rd_bits_o = ~locked_o;
   end

endmodule

// File: rtl/pb_seq_fsm.sv
module pb_seq_fsm
   import pb_pkg::*;
#(
   parameter int N_BITS = 16,
   parameter int IW     = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          seq_pgm_o,
   output logic [IW-1:0] seq_idx_o,
   output logic          seq_ers_o
);

   localparam logic [IW-1:0] LAST_IDX = IW'(N_BITS - 1);

   pb_state_e     st_q;
   logic [IW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE, ST_FIN: begin
               if (start_i) begin
                  st_q  <= ST_PRE;
                  cnt_q <= '0;
               end else begin
                  st_q  <= ST_IDLE;
               end
            end
            ST_PRE: begin
               if (cnt_q == LAST_IDX) begin
                  st_q <= ST_ERS;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_ERS: begin
               st_q <= ST_FIN;
            end
            default: begin
               st_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign busy_o    = (st_q == ST_PRE) || (st_q == ST_ERS);
   assign done_o    = (st_q == ST_FIN);
   assign seq_pgm_o = (st_q == ST_PRE);
   assign seq_idx_o = cnt_q;
   assign seq_ers_o = (st_q == ST_ERS);

endmodule

// File: rtl/pb_req_arb.sv
module pb_req_arb #(
   parameter int N_BITS = 16,
   parameter int IW     = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          busy_i,
   input  logic          all_locked_i,
   input  logic          erase_all_i,
   input  logic          prog_i,
   input  logic [IW-1:0] prog_idx_i,
   input  logic          raw_erase_i,
   input  logic          seq_pgm_i,
   input  logic [IW-1:0] seq_idx_i,
   input  logic          seq_ers_i,
   output logic          start_o,
   output logic          pgm_pulse_o,
   output logic [IW-1:0] pgm_idx_o,
   output logic          ers_pulse_o,
   output logic          err_o
);

   localparam bit IDX_FULL = ((1 << IW) == N_BITS);

   logic idx_ok;
   logic ers_try;
   logic ers_ok;
   logic pgm_ok;
   logic err_q;

   // out-of-range check only needed when index space exceeds the bank
   if (IDX_FULL) begin : g_idx_full
      assign idx_ok = 1'b1;
   end else begin : g_idx_range
      assign idx_ok = (prog_idx_i < IW'(N_BITS));
   end

   // priority: erase-all, then bare erase, then single program
   assign start_o = !busy_i && erase_all_i;
   assign ers_try = !busy_i && !erase_all_i && raw_erase_i;
   assign ers_ok  = ers_try && all_locked_i;
   assign pgm_ok  = !busy_i && !erase_all_i && !raw_erase_i && prog_i && idx_ok;

   assign pgm_pulse_o = seq_pgm_i || pgm_ok;
   assign pgm_idx_o   = seq_pgm_i ? seq_idx_i : prog_idx_i;
   assign ers_pulse_o = seq_ers_i || ers_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else if (ers_try && !all_locked_i) begin
         err_q <= 1'b1;
      end
   end

   assign err_o = err_q;

endmodule

// File: rtl/pb_erase_ctrl.sv
module pb_erase_ctrl #(
   parameter int N_BITS         = 16,
   parameter bit PROG_READS_ONE = 1'b0,
   localparam int IW            = (N_BITS > 1) ? $clog2(N_BITS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              erase_all_i,
   input  logic              prog_i,
   input  logic [IW-1:0]     prog_idx_i,
   input  logic              raw_erase_i,
   output logic [N_BITS-1:0] locked_o,
   output logic [N_BITS-1:0] rd_bits_o,
   output logic              pgm_pulse_o,
   output logic [IW-1:0]     pgm_idx_o,
   output logic              ers_pulse_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o
);

   if (N_BITS < 2 || N_BITS > 1024) begin : g_bad_n
      $error("pb_erase_ctrl: N_BITS must lie in 2..1024");
   end

   logic          start;
   logic          seq_pgm;
   logic [IW-1:0] seq_idx;
   logic          seq_ers;
   logic          all_locked;

   assign all_locked = &locked_o;

   pb_seq_fsm #(
      .N_BITS (N_BITS),
      .IW     (IW)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .busy_o    (busy_o),
      .done_o    (done_o),
      .seq_pgm_o (seq_pgm),
      .seq_idx_o (seq_idx),
      .seq_ers_o (seq_ers)
   );

   pb_req_arb #(
      .N_BITS (N_BITS),
      .IW     (IW)
   ) u_arb (
      .clk          (clk),
      .rst_n        (rst_n),
      .busy_i       (busy_o),
      .all_locked_i (all_locked),
      .erase_all_i  (erase_all_i),
      .prog_i       (prog_i),
      .prog_idx_i   (prog_idx_i),
      .raw_erase_i  (raw_erase_i),
      .seq_pgm_i    (seq_pgm),
      .seq_idx_i    (seq_idx),
      .seq_ers_i    (seq_ers),
      .start_o      (start),
      .pgm_pulse_o  (pgm_pulse_o),
      .pgm_idx_o    (pgm_idx_o),
      .ers_pulse_o  (ers_pulse_o),
      .err_o        (err_o)
   );

   pb_cell_bank #(
      .N_BITS         (N_BITS),
      .IW             (IW),
      .PROG_READS_ONE (PROG_READS_ONE)
   ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .pgm_pulse_i (pgm_pulse_o),
      .pgm_idx_i   (pgm_idx_o),
      .ers_pulse_i (ers_pulse_o),
      .locked_o    (locked_o),
      .rd_bits_o   (rd_bits_o)
   );

endmodule

// File: rtl/pb_erase_ctrl_chk.sv
module pb_erase_ctrl_chk #(
   parameter int N_BITS = 16,
   localparam int IW    = (N_BITS > 1) ? $clog2(N_BITS) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_BITS-1:0] locked_o,
   input logic              pgm_pulse_o,
   input logic [IW-1:0]     pgm_idx_o,
   input logic              ers_pulse_o,
   input logic              busy_o,
   input logic              done_o,
   input logic              err_o
);

   localparam logic [IW-1:0] LAST_IDX = IW'(N_BITS - 1);

   p_pulse_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(pgm_pulse_o && ers_pulse_o));

   p_erase_only_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ers_pulse_o |-> (&locked_o));

   p_prog_sets_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pgm_pulse_o && !ers_pulse_o) |=> locked_o[$past(pgm_idx_o)]);

   p_seq_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (pgm_pulse_o && pgm_idx_o == '0));

   p_seq_ascend_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && pgm_pulse_o && pgm_idx_o != LAST_IDX)
         |=> (busy_o && pgm_pulse_o && pgm_idx_o == $past(pgm_idx_o) + 1'b1));

   p_seq_erase_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && pgm_pulse_o && pgm_idx_o == LAST_IDX) |=> (busy_o && ers_pulse_o));

   p_erase_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ers_pulse_o |=> (locked_o == '0));

   p_done_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o) && $past(ers_pulse_o)));

   p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);

   p_err_idle_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> (!$past(busy_o) && !$past(ers_pulse_o)));

endmodule

bind pb_erase_ctrl pb_erase_ctrl_chk #(
   .N_BITS (N_BITS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .locked_o    (locked_o),
   .pgm_pulse_o (pgm_pulse_o),
   .pgm_idx_o   (pgm_idx_o),
   .ers_pulse_o (ers_pulse_o),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .err_o       (err_o)
);

// File: tb/pb_erase_ctrl_tb.sv
`timescale 1ns/1ps
module pb_erase_ctrl_tb;

   localparam int N  = 16;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          erase_all = 1'b0;
   logic          prog = 1'b0;
   logic [IW-1:0] prog_idx = '0;
   logic          raw_erase = 1'b0;

   logic [N-1:0]  locked, rd_bits, locked_b, rd_bits_b;
   logic          pgm, ers, busy, done, err;
   logic          pgm_b, ers_b, busy_b, done_b, err_b;
   logic [IW-1:0] pidx, pidx_b;

   int n_chk = 0;
   int n_bad = 0;
   logic [N-1:0] exp_lk = '0;

   always #2 clk = ~clk;

   pb_erase_ctrl #(.N_BITS(N), .PROG_READS_ONE(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .erase_all_i(erase_all), .prog_i(prog),
      .prog_idx_i(prog_idx), .raw_erase_i(raw_erase), .locked_o(locked),
      .rd_bits_o(rd_bits), .pgm_pulse_o(pgm), .pgm_idx_o(pidx),
      .ers_pulse_o(ers), .busy_o(busy), .done_o(done), .err_o(err));

   pb_erase_ctrl #(.N_BITS(N), .PROG_READS_ONE(1'b1)) u_dut_inv (
      .clk(clk), .rst_n(rst_n), .erase_all_i(erase_all), .prog_i(prog),
      .prog_idx_i(prog_idx), .raw_erase_i(raw_erase), .locked_o(locked_b),
      .rd_bits_o(rd_bits_b), .pgm_pulse_o(pgm_b), .pgm_idx_o(pidx_b),
      .ers_pulse_o(ers_b), .busy_o(busy_b), .done_o(done_b), .err_o(err_b));

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h @%0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_pol();
      chk(rd_bits == ~exp_lk, "R9 inverted read", 32'(rd_bits), 32'(~exp_lk));
      chk(rd_bits_b == exp_lk, "R9 direct read", 32'(rd_bits_b), 32'(exp_lk));
   endtask

   task automatic clear_in();
      erase_all = 1'b0; prog = 1'b0; raw_erase = 1'b0; prog_idx = '0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      exp_lk = '0;
      chk(locked == '0, "R1 locked", 32'(locked), 0);
      chk({busy, done, err, pgm, ers} == 5'b0, "R1 flags",
          32'({busy, done, err, pgm, ers}), 0);
      chk_pol();
   endtask

   task automatic host_prog(input int k);
      prog = 1'b1; prog_idx = IW'(k);
      #0.5;
      chk(pgm && pidx == IW'(k), "R2 pulse", 32'({pgm, pidx}), 32'({1'b1, IW'(k)}));
      @(negedge clk);
      clear_in();
      exp_lk[k] = 1'b1;
      chk(locked == exp_lk, "R2 bit locked", 32'(locked), 32'(exp_lk));
   endtask

   task automatic t_host_prog();
      host_prog(3);
      host_prog(N - 1);
      chk_pol();
   endtask

   // inject >= 0: at that sequence step also raise every conflicting request
   task automatic run_erase_all(input int inject);
      logic [N-1:0] prior;
      prior = exp_lk;
      erase_all = 1'b1;
      @(negedge clk);
      erase_all = 1'b0;
      chk(busy, "R3 busy rises", 32'(busy), 1);
      for (int k = 0; k < N; k++) begin
         logic [N-1:0] m;
         m = prior | ((N'(1) << k) - N'(1));
         if (k == inject) begin
            erase_all = 1'b1; raw_erase = 1'b1; prog = 1'b1; prog_idx = IW'(N - 1);
         end
         #0.5;
         chk(pgm && pidx == IW'(k) && !ers, "R3 preprogram order",
             32'({ers, pgm, pidx}), 32'({1'b0, 1'b1, IW'(k)}));
         chk(busy && locked == m, "R4 bits locked before erase",
             32'(locked), 32'(m));
         @(negedge clk);
         if (k == inject) begin
            clear_in();
            chk(locked == (prior | ((N'(1) << (k + 1)) - N'(1))),
                "R6 host prog ignored while busy", 32'(locked),
                32'(prior | ((N'(1) << (k + 1)) - N'(1))));
            chk(!err && busy, "R11 no error/no restart", 32'({busy, err}), 32'b10);
         end
      end
      #0.5;
      chk(ers && !pgm && busy, "R4 single erase pulse", 32'({busy, pgm, ers}), 32'b101);
      chk(&locked, "R4 all locked at erase", 32'(locked), 32'({N{1'b1}}));
      @(negedge clk);
      exp_lk = '0;
      chk(done && !busy && !ers, "R5 done strobe", 32'({done, busy, ers}), 32'b100);
      chk(locked == '0, "R5 all erased", 32'(locked), 0);
      chk_pol();
      @(negedge clk);
      chk(!done, "R5 done one cycle", 32'(done), 0);
   endtask

   task automatic t_raw_erase_ok();
      for (int k = 0; k < N; k++) host_prog(k);
      chk_pol();
      raw_erase = 1'b1; prog = 1'b1; prog_idx = IW'(2);
      #0.5;
      chk(ers && !pgm, "R10 raw erase beats prog", 32'({ers, pgm}), 32'b10);
      @(negedge clk);
      clear_in();
      exp_lk = '0;
      chk(locked == '0, "R8 raw erase clears", 32'(locked), 0);
      chk(!err, "R8 no error", 32'(err), 0);
   endtask

   task automatic t_priority_all();
      erase_all = 1'b1; raw_erase = 1'b1; prog = 1'b1; prog_idx = IW'(7);
      #0.5;
      chk(!pgm && !ers, "R10 erase_all wins", 32'({pgm, ers}), 0);
      @(negedge clk);
      clear_in();
      chk(busy && !err && pidx == '0, "R10 sequence started no error",
          32'({busy, err, pidx}), 32'({1'b1, 1'b0, IW'(0)}));
      for (int i = 0; i < 4 * N && !done; i++) @(negedge clk);
      chk(done && locked == '0, "R10 sequence completed", 32'({done, locked}),
          32'({1'b1, N'(0)}));
      @(negedge clk);
   endtask

   task automatic t_raw_erase_reject();
      host_prog(5);
      raw_erase = 1'b1;
      #0.5;
      chk(!ers, "R7 no erase pulse", 32'(ers), 0);
      @(negedge clk);
      clear_in();
      chk(err && locked == exp_lk, "R7 error set, bits kept",
          32'({err, locked}), 32'({1'b1, exp_lk}));
      repeat (3) @(negedge clk);
      chk(err, "R7 error sticky", 32'(err), 1);
      chk_pol();
   endtask

   initial begin
      #(200000 * 4);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_host_prog();
      run_erase_all(-1);
      run_erase_all(5);
      t_raw_erase_ok();
      t_priority_all();
      t_raw_erase_reject();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule